// File: doc/BRIEF.md
# PMBus Multi-Address Match Unit

This block sits behind a byte-level I2C/PMBus receiver and decides whether an incoming address byte targets this device. The byte carries the 7-bit address in bits 7:1 and the read/write flag in bit 0, where 1 means read. On the strobe of that byte, the unit checks the address against three kinds of target at once:

- two fixed global addresses that are always answered;
- a device address held in a register, which can be disabled and whose bits can be partly replaced by strap inputs;
- one rail address per channel, chosen through a page register.

One clock later the unit reports four things: whether to acknowledge, which kind of target matched, which channels a rail address hit, and a single-cycle communication-fault pulse when a rail address is read.

Configuration arrives as byte writes from the command layer: the device address, the page, and the rail address of the channels the page selects. Each strap input is a 4-bit field with a valid flag, and a valid field always wins over the stored bits it covers.

Top module: `pmbus_addr_match`

## Requirements
- R1: Addresses 0x5A and 0x5B are acknowledged with match code 1 (global), for reads and for writes, whatever the device and rail configuration holds.
- R2: When the device register has bit 7 clear, an address equal to the effective device address is acknowledged with match code 2 (device), for reads and for writes.
- R3: A device register value with bit 7 set (0x80 is the canonical value) disables device matching; such an address then gets no device match.
- R4: The effective device address takes bits 3:0 from the low strap field when that field is valid, and bits 6:4 from bits 2:0 of the high strap field when that field is valid. Bits not covered by a valid field come from the device register. With both fields invalid, the effective address is bits 6:0 of the register.
- R5: A rail write updates the rail register of the channels the page selects. Page 0 selects channel 0, page 1 selects channel 1, and page 0xFF selects both. Any other page selects no channel.
- R6: A write addressed to a rail address is acknowledged with match code 3 (rail). The channel mask has bit i set for every channel i whose enabled rail register holds that address.
- R7: A read addressed to a rail address gives a one-cycle fault pulse with match code 3 and the channel mask set, and is not acknowledged.
- R8: A rail register with bit 7 set (0x80 is the canonical value) disables rail matching for that channel only.
- R9: Priority is global, then device, then rail. The channel mask is nonzero only for a rail match, and no fault is raised when a higher class matches.
- R10: The outputs are registered. They show the decision in the one cycle after the address strobe and are all zero in every other cycle. An address matching nothing gives ack 0 and match code 0.
- R11: After reset the device register holds 0x4F, both rail registers hold 0x80, and the page is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | 1 | Strobe for the address byte |
| addr_byte | input | 8 | Address in bits 7:1, read flag in bit 0 |
| dev_wr | input | 1 | Write wr_data into the device address register |
| rail_wr | input | 1 | Write wr_data into the rail register of the paged channels |
| page_wr | input | 1 | Write wr_data into the page register |
| wr_data | input | 8 | Configuration write data |
| strap_lo_valid | input | 1 | Low strap field is valid |
| strap_lo | input | 4 | Replacement for device address bits 3:0 |
| strap_hi_valid | input | 1 | High strap field is valid |
| strap_hi | input | 4 | Bits 2:0 replace device address bits 6:4 |
| ack | output | 1 | Acknowledge decision |
| match_kind | output | 2 | 0 none, 1 global, 2 device, 3 rail |
| chan_mask | output | NCH | Channels hit by a rail match |
| cml_fault | output | 1 | Pulse for a read at a rail address |

## Verification
The hardest situations to reach are overlaps between classes. A rail register or the effective device address can equal a global address, or two channels can share a rail address while one of them is disabled. Random address probing almost never lands on these. The stimulus therefore draws addresses mostly from the values currently loaded in the registers and the strap-built device address, plus the two global addresses, and directed steps place a rail address on a global and on the device address. Page writes use 0, 1, 0xFF and stray values, so both shared and disabled rails come up repeatedly.

// File: rtl/pmbus_addr_match.sv
module pmbus_addr_match #(
  parameter int          NCH       = 2,
  parameter logic [7:0]  DEV_RESET = 8'h4F,
  parameter logic [6:0]  GLOBAL_A  = 7'h5A,
  parameter logic [6:0]  GLOBAL_B  = 7'h5B
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           addr_valid,
  input  logic [7:0]     addr_byte,
  input  logic           dev_wr,
  input  logic           rail_wr,
  input  logic           page_wr,
  input  logic [7:0]     wr_data,
  input  logic           strap_lo_valid,
  input  logic [3:0]     strap_lo,
  input  logic           strap_hi_valid,
  input  logic [3:0]     strap_hi,
  output logic           ack,
  output logic [1:0]     match_kind,
  output logic [NCH-1:0] chan_mask,
  output logic           cml_fault
);

  localparam logic [1:0] K_NONE = 2'd0, K_GLOB = 2'd1, K_DEV = 2'd2, K_RAIL = 2'd3;

  logic [7:0]     dev_reg, page_reg;
  logic [7:0]     rail_reg [NCH];
  logic [NCH-1:0] page_sel, rail_hit;
  logic [6:0]     a, eff_dev;
  logic           rd, is_glob, is_dev;

  assign a       = addr_byte[7:1];
  assign rd      = addr_byte[0];
  assign eff_dev = {strap_hi_valid ? strap_hi[2:0] : dev_reg[6:4],
                    strap_lo_valid ? strap_lo      : dev_reg[3:0]};
  assign is_glob = (a == GLOBAL_A) || (a == GLOBAL_B);
  assign is_dev  = !dev_reg[7] && (a == eff_dev);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dev_reg  <= DEV_RESET;
      page_reg <= 8'h00;
    end else begin
      if (dev_wr)  dev_reg  <= wr_data;
      if (page_wr) page_reg <= wr_data;
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign page_sel[i] = (page_reg == 8'(i)) || (page_reg == 8'hFF);
    assign rail_hit[i] = !rail_reg[i][7] && (rail_reg[i][6:0] == a);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     rail_reg[i] <= 8'h80;
      else if (rail_wr && page_sel[i]) rail_reg[i] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack        <= 1'b0;
      match_kind <= K_NONE;
      chan_mask  <= '0;
      cml_fault  <= 1'b0;
    end else begin
      ack        <= 1'b0;
      match_kind <= K_NONE;
      chan_mask  <= '0;
      cml_fault  <= 1'b0;
      if (addr_valid) begin
        if (is_glob) begin
          ack <= 1'b1; match_kind <= K_GLOB;
        end else if (is_dev) begin
          ack <= 1'b1; match_kind <= K_DEV;
        end else if (|rail_hit) begin
          match_kind <= K_RAIL;
          chan_mask  <= rail_hit;
          ack        <= !rd;
          cml_fault  <= rd;
        end
      end
    end

  AST_GLOBAL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && (addr_byte[7:1] == GLOBAL_A || addr_byte[7:1] == GLOBAL_B)
    |=> ack && match_kind == K_GLOB); // R1
  AST_FAULT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cml_fault |-> !ack && match_kind == K_RAIL && chan_mask != '0); // R7
  AST_MASK_RAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    chan_mask != '0 |-> match_kind == K_RAIL); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> !ack && match_kind == K_NONE && chan_mask == '0 && !cml_fault); // R10
  AST_FAULT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_byte[0] |=> !cml_fault); // R7
  AST_DEV_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && dev_reg[7] |=> match_kind != K_DEV); // R3

endmodule

// File: tb/tb_pmbus_addr_match.sv
module tb_pmbus_addr_match;
  logic clk = 0, rst_n = 0;
  logic addr_valid = 0, dev_wr = 0, rail_wr = 0, page_wr = 0;
  logic [7:0] addr_byte = 0, wr_data = 0;
  logic strap_lo_valid = 0, strap_hi_valid = 0;
  logic [3:0] strap_lo = 0, strap_hi = 0;
  logic ack, cml_fault;
  logic [1:0] match_kind, chan_mask;
  int checks = 0, failures = 0;
  logic [7:0] m_dev = 8'h4F, m_page = 8'h00;
  logic [7:0] m_rail [2] = '{8'h80, 8'h80};

  always #4 clk = ~clk;

  pmbus_addr_match dut (.*);

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [6:0] eff_dev();
    return {strap_hi_valid ? strap_hi[2:0] : m_dev[6:4], strap_lo_valid ? strap_lo : m_dev[3:0]};
  endfunction

  // packed {ack, kind[1:0], mask[1:0], fault}
  function automatic logic [5:0] expect_of(logic [7:0] ab);
    logic [6:0] a = ab[7:1];
    logic [1:0] hit;
    hit[0] = !m_rail[0][7] && m_rail[0][6:0] == a;
    hit[1] = !m_rail[1][7] && m_rail[1][6:0] == a;
    if (a == 7'h5A || a == 7'h5B) return {1'b1, 2'd1, 2'b00, 1'b0};
    if (!m_dev[7] && a == eff_dev()) return {1'b1, 2'd2, 2'b00, 1'b0};
    if (hit != 0) return {!ab[0], 2'd3, hit, ab[0]};
    return 6'b0;
  endfunction

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual ack/kind/mask/fault=%b expected %b", req, act, exp);
    end
  endtask

  task automatic cfg(int which, logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    dev_wr = (which == 0); page_wr = (which == 1); rail_wr = (which == 2);
    @(negedge clk);
    dev_wr = 0; page_wr = 0; rail_wr = 0;
    if (which == 0) m_dev = d;
    if (which == 1) m_page = d;
    if (which == 2) begin
      if (m_page == 8'h00 || m_page == 8'hFF) m_rail[0] = d;
      if (m_page == 8'h01 || m_page == 8'hFF) m_rail[1] = d;
    end
  endtask

  task automatic probe(string req, logic [6:0] a, logic r);
    logic [5:0] e;
    @(negedge clk);
    addr_byte = {a, r}; addr_valid = 1;
    e = expect_of({a, r});
    @(negedge clk);
    addr_valid = 0;
    chk(req, {ack, match_kind, chan_mask, cml_fault}, e);
  endtask

  task automatic quiet(string req);
    @(negedge clk);
    chk(req, {ack, match_kind, chan_mask, cml_fault}, 6'b0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {ack, match_kind, chan_mask, cml_fault}, 6'b0);
    rst_n = 1;
    probe("R11 reset dev addr 0x4F", 7'h4F, 1);
    probe("R11 rails disabled at reset", 7'h00, 0);
    probe("R1 global 0x5A read", 7'h5A, 1);
    probe("R1 global 0x5B write", 7'h5B, 0);
    quiet("R10 quiet after strobe");
    cfg(0, 8'h80);
    probe("R3 device disabled", 7'h00, 1);
    probe("R3 device disabled old addr", 7'h4F, 0);
    cfg(0, 8'h31);
    probe("R2 device write", 7'h31, 0);
    probe("R2 device read", 7'h31, 1);
    strap_lo_valid = 1; strap_lo = 4'hC;
    probe("R4 low strap replaces nibble", 7'h3C, 1);
    probe("R4 stored nibble no longer matches", 7'h31, 0);
    strap_hi_valid = 1; strap_hi = 4'hD;
    probe("R4 both straps", 7'h5C, 0);
    strap_lo_valid = 0;
    probe("R4 high strap only", 7'h51, 1);
    strap_hi_valid = 0;
    probe("R4 no straps", 7'h31, 1);
    cfg(1, 8'h00); cfg(2, 8'h22);
    probe("R5 page0 writes ch0 R6 write ack", 7'h22, 0);
    cfg(1, 8'h01); cfg(2, 8'h22);
    probe("R6 shared rail mask both", 7'h22, 0);
    probe("R7 rail read faults", 7'h22, 1);
    quiet("R7 fault single cycle");
    cfg(2, 8'h80);
    probe("R8 ch1 disabled only", 7'h22, 0);
    cfg(1, 8'h07); cfg(2, 8'h33);
    probe("R5 stray page writes nothing", 7'h33, 0);
    cfg(1, 8'hFF); cfg(2, 8'h44);
    probe("R5 page FF writes both", 7'h44, 1);
    cfg(2, 8'h5A);
    probe("R9 global beats rail read", 7'h5A, 1);
    cfg(2, 8'h31);
    probe("R9 device beats rail read", 7'h31, 1);
    probe("R10 no match", 7'h7E, 0);
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] d;
      int pick = $urandom_range(0, 5);
      d = (pick == 0) ? 8'h80 : {1'b0, 7'($urandom_range(0, 127))};
      if (op == 0) cfg(0, d);
      else if (op == 1) begin
        pick = $urandom_range(0, 3);
        cfg(1, pick == 0 ? 8'h00 : pick == 1 ? 8'h01 : pick == 2 ? 8'hFF : 8'($urandom));
      end else if (op == 2) cfg(2, d);
      else begin
        logic [6:0] a;
        strap_lo_valid = 1'($urandom); strap_lo = 4'($urandom);
        strap_hi_valid = 1'($urandom); strap_hi = 4'($urandom);
        pick = $urandom_range(0, 4);
        a = pick == 0 ? m_rail[0][6:0] : pick == 1 ? m_rail[1][6:0] :
            pick == 2 ? eff_dev() : pick == 3 ? 7'h5A + 7'($urandom_range(0, 1)) : 7'($urandom);
        probe("R2 R6 R7 R9 random", a, 1'($urandom));
        if (op == 9) quiet("R10 random quiet");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule